// File: doc/BRIEF.md
# Phase-Selected Counter-Comparator PWM Core

This block turns an 8-bit duty word into a single PWM gate signal with a resolution of 1/256 of the switching period, while the system clock runs at only 16 times the switching frequency. A 4-bit counter places the rising edge at the start of every period and picks the system clock cycle in which the falling edge occurs. Inside that cycle, the falling edge is placed to one sixteenth of a clock period by the rising edge of SC. SC is the AND of one of four coarse phase clocks and one of four fine phase clocks, each chosen by two bits of the duty word.

The phase clocks come from outside, usually from clock managers. All phase clocks share their timing reference with the system clock. They are shaped as narrow pulses: coarse phase k is high for the quarter period starting at k/4 of a clock period; fine phase j repeats four times per clock period and rises at j/16 of a clock period. They lag the system clock by a small fixed insertion skew. With this shaping the AND of any pair pulses exactly once per system clock cycle, and every pair is low at the system clock edge. The duty word may change at any time. It takes effect at the next period boundary.

Top module: `phase_pwm_core`

## Requirements
- R1: The 4-bit counter advances by one on every system clock edge and wraps from 15 to 0, so one switching period is 16 clock cycles. The output rises at the clock edge where the counter goes from 15 to 0, when the latched duty word is nonzero.
- R2: The output stays high from that rising edge until the clock cycle whose counter value equals duty bits [7:4]. In that cycle it falls on the first rising edge of SC. The output is high in every earlier cycle of the period and low at the end of the matching cycle.
- R3: Duty bits [3:2] select coarse_ph bit 0..3 (0, 90, 180, 270 degrees) for codes 00..11. Duty bits [1:0] select fine_ph bit 0..3 in the same way. SC is the AND of the two selections. The high time is therefore duty x Tclk/16, plus the phase clock skew.
- R4: A latched duty word of 0 keeps the output low for the whole period, with no pulse.
- R5: The duty word is sampled only at the clock edge where the counter wraps. A change at any other point has no effect on the current period.
- R6: A nonzero duty word gives exactly one pulse per period. When bits [7:4] are 0, the clear in counter cycle 0 wins over the set, which gives a pulse shorter than one clock cycle.
- R7: An asynchronous reset forces the counter and the latched duty word to 0 and the output low. The first period after reset produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 16 times the switching frequency |
| rst | input | 1 | Asynchronous reset, active high |
| coarse_ph | input | 4 | Coarse phase clocks, bit k shifted by k quarter clock periods |
| fine_ph | input | 4 | Fine phase clocks, bit j shifted by j sixteenths of a clock period |
| duty_in | input | 8 | Duty word: [7:4] counter match, [3:2] coarse select, [1:0] fine select |
| pwm | output | 1 | PWM gate output |

## Verification
On every system clock edge, the assertions check the counter step, the rule that the duty word is only latched at the wrap, the low output for a zero duty word, and the output level relative to the counter match cycle. They also check that reset holds the output low. Edge positions below one clock cycle cannot be seen at clock edges. The bench therefore measures each pulse in real time against duty x Tclk/16 plus skew, under directed corners and random duty words that change at random points of the period. The bench alone shows the pulse count per period and the sub-cycle clear in counter cycle 0.

// File: rtl/phase_pwm_core.sv
`timescale 1ns/1ps
module phase_pwm_core #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2,
  localparam int NPH = 2**SEL_W,
  localparam int DUTY_W = CNT_W + 2*SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPH-1:0]    coarse_ph,
  input  logic [NPH-1:0]    fine_ph,
  input  logic [DUTY_W-1:0] duty_in,
  output logic              pwm
);

  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] duty_q;
  logic              wrap;
  logic              armed;
  logic              s1;
  logic              s2;
  logic              sc;
  logic              set_tog;
  logic              clr_tog;

  assign wrap  = &cnt;
  assign armed = (|duty_q) && (cnt == duty_q[DUTY_W-1 -: CNT_W]);
  assign s1    = coarse_ph[duty_q[2*SEL_W-1 -: SEL_W]];
  assign s2    = fine_ph[duty_q[SEL_W-1:0]];
  assign sc    = s1 & s2;

  // period counter, duty latch and set toggle
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt     <= '0;
      duty_q  <= '0;
      set_tog <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) begin
        duty_q <= duty_in;
        if (|duty_in) set_tog <= ~set_tog;
      end
    end
  end

  // sub-cycle clear, clocked by the selected phase event
  always_ff @(posedge sc or posedge rst) begin
    if (rst) clr_tog <= 1'b0;
    else if (armed) clr_tog <= set_tog;
  end

  assign pwm = set_tog ^ clr_tog;

endmodule

// File: rtl/phase_pwm_core_chk.sv
`timescale 1ns/1ps
module phase_pwm_core_chk #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DUTY_W-1:0] duty_in,
  input logic [DUTY_W-1:0] duty_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              pwm
);

  logic [CNT_W-1:0] match;
  assign match = duty_q[DUTY_W-1 -: CNT_W];

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + 1'b1);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt != {CNT_W{1'b1}}) |=> $stable(duty_q));

  assert_latch_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == {CNT_W{1'b1}}) |=> duty_q == $past(duty_in));

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |-> !pwm);

  assert_high_before_match_R2: assert property (@(posedge clk) disable iff (rst)
    (duty_q != '0 && cnt < match) |-> pwm);

  assert_low_after_match_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt == match) |-> !pwm);

  always @(negedge clk) begin
    if (rst) begin
      assert_reset_low_R7: assert (!pwm && cnt == '0 && duty_q == '0)
        else $error("reset state not held");
    end
  end

endmodule

bind phase_pwm_core phase_pwm_core_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rst(rst), .duty_in(duty_in), .duty_q(duty_q), .cnt(cnt), .pwm(pwm)
);

// File: tb/phase_pwm_core_tb.sv
`timescale 1ns/1ps
module phase_pwm_core_tb;
  localparam real TCLK = 4.0;
  localparam real STEP = TCLK / 16.0;
  localparam real SKEW = 0.05;
  localparam int  NSEQ = 70;

  logic       clk;
  logic       rst;
  logic [3:0] coarse_ph;
  logic [3:0] fine_ph;
  logic [7:0] duty;
  logic       pwm;

  int unsigned hc = 0;
  int unsigned hd = 0;
  int checks = 0;
  int failures = 0;
  int nfall = 0;
  real t_rise = 0.0;
  real last_w = 0.0;
  bit done = 0;

  phase_pwm_core u_dut (
    .clk(clk), .rst(rst), .coarse_ph(coarse_ph), .fine_ph(fine_ph),
    .duty_in(duty), .pwm(pwm)
  );

  // 250 MHz clock built from a 1/32-period phase counter; phase clocks lag by SKEW
  initial forever #(TCLK/32.0) hc = (hc + 1) % 32;
  initial begin #(SKEW); forever #(TCLK/32.0) hd = (hd + 1) % 32; end
  assign clk = (hc < 16);
  for (genvar k = 0; k < 4; k++) begin : g_ph
    assign coarse_ph[k] = (((hd + 32 - 8*k) % 32) < 8);
    assign fine_ph[k]   = (((hd + 32 - 2*k) % 8) < 1);
  end

  always @(posedge pwm) t_rise = $realtime;
  always @(negedge pwm) begin last_w = $realtime - t_rise; nfall++; end

  function automatic real exp_width(int d);
    return d * STEP + SKEW;
  endfunction

  function automatic real absr(real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic chk(bit ok, string tag, string what, real act, real expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0f expected=%0f", tag, what, act, expv);
    end
  endtask

  initial begin
    #(200000 * TCLK);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seq [NSEQ+1];
    int dprev;
    int dcur;
    int snap;
    real tb;
    void'($urandom(32'd57319));
    seq[0] = 8'h56; seq[1] = 8'h01; seq[2] = 8'h00; seq[3] = 8'hFF;
    seq[4] = 8'h10; seq[5] = 8'h0F; seq[6] = 8'h03; seq[7] = 8'hF0;
    seq[8] = 8'h00; seq[9] = 8'h00; seq[10] = 8'h5A; seq[11] = 8'h02;
    for (int i = 12; i < NSEQ; i++) seq[i] = (($urandom % 8) == 0) ? 0 : int'($urandom % 256);
    seq[NSEQ] = 8'hC0;

    rst  = 1'b1;
    duty = 8'hC3;
    repeat (3) @(negedge clk);
    #0.1;
    chk(pwm == 1'b0, "R7", "output during reset", real'(pwm), 0.0);
    @(negedge clk);
    rst   = 1'b0;
    nfall = 0;
    snap  = 0;
    duty  = seq[0][7:0];
    dprev = 0;
    repeat (16) @(posedge clk);
    tb = $realtime;
    #0.1;

    for (int i = 0; i < NSEQ; i++) begin
      int n;
      int c;
      dcur = seq[i];
      n = nfall - snap;
      if (i == 0)
        chk(n == 0, "R7", "pulses in first period after reset", real'(n), 0.0);
      else if (dprev == 0)
        chk(n == 0, "R4", "pulses with zero duty", real'(n), 0.0);
      else
        chk(n == 1, "R6", "pulses per period", real'(n), 1.0);
      if (dprev != 0 && n == 1)
        chk(absr(last_w - exp_width(dprev)) < 0.02, "R3/R5", "pulse width ns",
            last_w, exp_width(dprev));
      if (dcur == 0)
        chk(pwm == 1'b0, "R4", "level after wrap with zero duty", real'(pwm), 0.0);
      else begin
        chk(pwm == 1'b1, "R2", "level after wrap", real'(pwm), 1.0);
        chk(absr(t_rise - tb) < 0.01, "R1", "rise time at wrap ns", t_rise, tb);
      end
      snap = nfall;
      c = 1 + int'($urandom % 16);
      repeat (c) @(negedge clk);
      duty = seq[i+1][7:0];
      repeat (17 - c) @(posedge clk);
      tb = $realtime;
      #0.1;
      dprev = dcur;
    end

    chk(pwm == 1'b1, "R2", "level at start of last period", real'(pwm), 1.0);
    #1.0;
    rst = 1'b1;
    #0.1;
    chk(pwm == 1'b0, "R7", "output after mid-pulse reset", real'(pwm), 0.0);
    repeat (2) @(negedge clk);
    chk(pwm == 1'b0, "R7", "output held in reset", real'(pwm), 0.0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule